// File: doc/BRIEF.md
# Duplex Error-Latency Monitor

This block sits beside a redundant pair of combinational modules and measures how long that pair stays trustworthy after faults are introduced. It drives the shared input vector from a wrapping counter that can be loaded with a seed. The counter takes one step per clock. Each cycle it takes the first copy's output, the second copy's output and a fault-free reference output. It then sorts the cycle into one of three classes: all correct, a detected mismatch, or a silent integrity loss in which both copies are wrong in exactly the same way.

The second copy may be built in complemented form, driving its result through inverters. A parameter tells the monitor to re-invert that copy before any comparison. A start pulse marks the cycle in which the faults take effect. From then on the monitor counts cycles until the first silent-loss cycle and holds that count as the error latency. If no such cycle occurs within 10,000 cycles, the fault pair is declared compensating and the latency saturates at that cap. A sticky flag records whether any mismatch has been seen since the last start.

Top module: `duplex_latency_mon`

## Requirements
- R1: The vector output takes the value `SEED` (default 8'h01) on reset. It takes `seed_val` on the edge after `seed_load` is high. On every other edge it increments by one, wrapping modulo 2^IN_W.
- R2: `cls` classifies the current cycle combinationally: 2'b00 when both copies equal the reference, 2'b10 when both differ from the reference with identical values, and 2'b01 in every other case. 2'b11 never appears.
- R3: With `B_INVERTED` = 1 (the default), `out_b` is bitwise inverted before it is compared, so a healthy complemented copy presents the inverse of the reference.
- R4: An edge with `start` high clears `latency`, `done`, `compensating` and `detected`, sets `busy`, and zeroes the cycle count. The class of the start cycle itself is ignored.
- R5: While busy, the first silent-loss cycle that is the k-th cycle after the start edge loads k into `latency`, sets `done` and clears `busy`.
- R6: If CAP cycles (10,000 by default) pass after the start edge with no silent-loss cycle, `latency` becomes CAP and both `done` and `compensating` rise. A silent loss in the CAP-th cycle itself counts as a normal finish.
- R7: After finishing, `done`, `compensating` and `latency` hold their values until the next start or reset, whatever classes follow.
- R8: `detected` rises on the edge after any mismatch cycle (class 2'b01) and stays high until a start edge or reset.
- R9: Synchronous active-high `rst` clears `busy`, `done`, `compensating`, `detected` and `latency`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_load | input | 1 | Load `seed_val` into the vector counter |
| seed_val | input | IN_W | Seed value |
| start | input | 1 | Faults applied this cycle; begin a measurement |
| vec_out | output | IN_W | Shared input vector for both copies and the reference |
| ref_out | input | OUT_W | Fault-free reference output |
| out_a | input | OUT_W | First copy output |
| out_b | input | OUT_W | Second copy output (complemented when `B_INVERTED`) |
| cls | output | 2 | Class of the current cycle |
| detected | output | 1 | Sticky mismatch flag |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Measurement finished |
| compensating | output | 1 | Finished at the cap with no silent loss |
| latency | output | CNT_W | Measured error latency |

## Verification
The bench targets the off-by-one in the latency count: a silent loss placed exactly five cycles after the start must read 5, and a design that counted the start cycle would report 6. A pair whose errors never coincide must run the full 10,000 cycles and saturate. A design that never saturates would hang, and the watchdog catches that. Another scenario sends silent-loss cycles after a measurement has finished, which catches a latency that gets overwritten. A run from seed 8'hFE checks the counter wrap. A mismatch-only phase checks that the sticky flag survives later clean cycles and clears only on start. A design that skipped the inversion of the second copy would flag every healthy cycle as a mismatch.

// File: rtl/duplex_latency_mon.sv
module duplex_latency_mon #(
  parameter int IN_W = 8,
  parameter int OUT_W = 4,
  parameter int CNT_W = 14,
  parameter int CAP = 10000,
  parameter logic [IN_W-1:0] SEED = 1,
  parameter bit B_INVERTED = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seed_load,
  input  logic [IN_W-1:0]  seed_val,
  input  logic             start,
  output logic [IN_W-1:0]  vec_out,
  input  logic [OUT_W-1:0] ref_out,
  input  logic [OUT_W-1:0] out_a,
  input  logic [OUT_W-1:0] out_b,
  output logic [1:0]       cls,
  output logic             detected,
  output logic             busy,
  output logic             done,
  output logic             compensating,
  output logic [CNT_W-1:0] latency
);
  localparam logic [1:0] C_OK = 2'b00, C_MIS = 2'b01, C_LOSS = 2'b10;
  localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAP);

  logic [OUT_W-1:0] b_true;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             a_ok, b_ok, loss;

  assign b_true  = B_INVERTED ? ~out_b : out_b;
  assign a_ok    = (out_a == ref_out);
  assign b_ok    = (b_true == ref_out);
  assign loss    = !a_ok && (out_a == b_true);
  assign cls     = (a_ok && b_ok) ? C_OK : (loss ? C_LOSS : C_MIS);
  assign cnt_nxt = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)            vec_out <= SEED;
    else if (seed_load) vec_out <= seed_val;
    else                vec_out <= vec_out + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt          <= '0;
      busy         <= 1'b0;
      done         <= 1'b0;
      compensating <= 1'b0;
      detected     <= 1'b0;
      latency      <= '0;
    end else if (start) begin
      cnt          <= '0;
      busy         <= 1'b1;
      done         <= 1'b0;
      compensating <= 1'b0;
      detected     <= 1'b0;
      latency      <= '0;
    end else begin
      if (cls == C_MIS) detected <= 1'b1;
      if (busy) begin
        cnt <= cnt_nxt;
        if (loss) begin
          latency <= cnt_nxt;
          done    <= 1'b1;
          busy    <= 1'b0;
        end else if (cnt_nxt == CAP_V) begin
          latency      <= CAP_V;
          done         <= 1'b1;
          compensating <= 1'b1;
          busy         <= 1'b0;
        end
      end
    end
  end
endmodule

module duplex_latency_mon_chk #(
  parameter int IN_W = 8,
  parameter int CNT_W = 14,
  parameter int CAP = 10000
) (
  input logic             clk,
  input logic             rst,
  input logic             seed_load,
  input logic             start,
  input logic [IN_W-1:0]  vec_out,
  input logic [1:0]       cls,
  input logic             detected,
  input logic             done,
  input logic             compensating,
  input logic [CNT_W-1:0] latency
);
  p_vec_step_r1: assert property (@(posedge clk) disable iff (rst)
    !seed_load |=> vec_out == IN_W'($past(vec_out) + 1'b1));
  p_cls_legal_r2: assert property (@(posedge clk) disable iff (rst)
    cls != 2'b11);
  p_start_clear_r4: assert property (@(posedge clk) disable iff (rst)
    start |=> !done && !compensating && !detected && latency == '0);
  p_comp_done_r6: assert property (@(posedge clk) disable iff (rst)
    compensating |-> done);
  p_lat_cap_r6: assert property (@(posedge clk) disable iff (rst)
    latency <= CNT_W'(CAP));
  p_done_hold_r7: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> done && $stable(latency) && $stable(compensating));
  p_det_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    detected && !start |=> detected);
  p_det_set_r8: assert property (@(posedge clk) disable iff (rst)
    cls == 2'b01 && !start |=> detected);
endmodule

bind duplex_latency_mon duplex_latency_mon_chk #(
  .IN_W(IN_W), .CNT_W(CNT_W), .CAP(CAP)
) u_chk (
  .clk(clk), .rst(rst), .seed_load(seed_load), .start(start),
  .vec_out(vec_out), .cls(cls), .detected(detected), .done(done),
  .compensating(compensating), .latency(latency)
);

// File: tb/duplex_latency_mon_bench.sv
module duplex_latency_mon_bench;
  localparam int IN_W = 8, OUT_W = 4, CNT_W = 14, CAP = 10000;

  logic clk = 1'b0, rst = 1'b1, seed_load = 1'b0, start = 1'b0;
  logic [IN_W-1:0] seed_val = '0;
  logic [IN_W-1:0] vec_out;
  logic [OUT_W-1:0] ref_w, a_w, b_w;
  logic [1:0] cls;
  logic detected, busy, done, compensating;
  logic [CNT_W-1:0] latency;
  int mode = 0;
  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  function automatic logic [OUT_W-1:0] fn(input logic [IN_W-1:0] v);
    return v[3:0] ^ v[7:4];
  endfunction
  function automatic logic [OUT_W-1:0] err_a(input int m, input logic [IN_W-1:0] v);
    logic [OUT_W-1:0] f = fn(v);
    case (m)
      1, 2, 3: return {3'b0, ~f[0]};
      4:       return (v == 8'hA5) ? 4'hF : 4'h0;
      5:       return 4'b0010;
      default: return 4'h0;
    endcase
  endfunction
  function automatic logic [OUT_W-1:0] err_b(input int m, input logic [IN_W-1:0] v);
    logic [OUT_W-1:0] f = fn(v);
    case (m)
      2:       return {3'b0, ~f[0]};
      3:       return {2'b0, ~f[1], 1'b0};
      4:       return (v == 8'hA5) ? 4'hF : 4'h0;
      5:       return (v == 8'h10) ? 4'b0010 : 4'h0;
      default: return 4'h0;
    endcase
  endfunction

  assign ref_w = fn(vec_out);
  assign a_w   = fn(vec_out) ^ err_a(mode, vec_out);
  assign b_w   = ~(fn(vec_out) ^ err_b(mode, vec_out));

  duplex_latency_mon #(.IN_W(IN_W), .OUT_W(OUT_W), .CNT_W(CNT_W), .CAP(CAP)) u_duplex_latency_mon (
    .clk(clk), .rst(rst), .seed_load(seed_load), .seed_val(seed_val), .start(start),
    .vec_out(vec_out), .ref_out(ref_w), .out_a(a_w), .out_b(b_w), .cls(cls),
    .detected(detected), .busy(busy), .done(done), .compensating(compensating),
    .latency(latency));

  // Requirement-level class: R2 encoding, R3 inversion of copy B
  function automatic logic [1:0] exp_cls(input logic [OUT_W-1:0] r, a, b);
    logic [OUT_W-1:0] bt = ~b;
    if (a == r && bt == r) return 2'b00;
    if (a != r && a == bt) return 2'b10;
    return 2'b01;
  endfunction

  int m_vec = 1, m_cnt = 0, m_lat = 0;
  bit m_busy = 0, m_done = 0, m_comp = 0, m_det = 0;

  always @(posedge clk) begin
    logic [1:0] c;
    c = exp_cls(ref_w, a_w, b_w);
    if (rst) begin
      m_vec <= 1; m_cnt <= 0; m_lat <= 0;
      m_busy <= 0; m_done <= 0; m_comp <= 0; m_det <= 0;
    end else begin
      m_vec <= seed_load ? int'(seed_val) : (m_vec + 1) % 256;
      if (start) begin
        m_cnt <= 0; m_lat <= 0; m_busy <= 1; m_done <= 0; m_comp <= 0; m_det <= 0;
      end else begin
        if (c == 2'b01) m_det <= 1;
        if (m_busy) begin
          m_cnt <= m_cnt + 1;
          if (c == 2'b10) begin
            m_lat <= m_cnt + 1; m_done <= 1; m_busy <= 0;
          end else if (m_cnt + 1 == CAP) begin
            m_lat <= CAP; m_done <= 1; m_comp <= 1; m_busy <= 0;
          end
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk("R1 vec_out", int'(vec_out), m_vec);
      chk("R2 cls", int'(cls), int'(exp_cls(ref_w, a_w, b_w)));
      chk("R8 detected", int'(detected), int'(m_det));
      chk("R4 busy", int'(busy), int'(m_busy));
      chk("R5 done", int'(done), int'(m_done));
      chk("R6 compensating", int'(compensating), int'(m_comp));
      chk("R5 latency", int'(latency), m_lat);
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic load_and_start(input logic [IN_W-1:0] s, input int m);
    @(negedge clk); seed_load = 1'b1; seed_val = s;
    @(negedge clk); seed_load = 1'b0; start = 1'b1; mode = m;
    @(negedge clk); start = 1'b0;
  endtask
  task automatic wait_done;
    while (!done) @(negedge clk);
  endtask

  initial begin
    cycles(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset done", int'(done), 0);
    chk("R9 reset latency", int'(latency), 0);
    chk("R9 reset detected", int'(detected), 0);
    chk("R3 healthy complemented copy is class 00", int'(cls), 0);
    cycles(20);
    mode = 1; cycles(20);
    chk("R8 detected after mismatches", int'(detected), 1);
    mode = 0; cycles(5);
    chk("R8 detected stays set", int'(detected), 1);
    load_and_start(8'h30, 2);
    wait_done; cycles(2);
    chk("R4 detected cleared by start", int'(detected), 0);
    load_and_start(8'hA0, 4);
    wait_done; @(negedge clk);
    chk("R5 latency five cycles", int'(latency), 5);
    chk("R5 not compensating", int'(compensating), 0);
    mode = 2; cycles(30);
    chk("R7 latency held after later losses", int'(latency), 5);
    load_and_start(8'h08, 5);
    wait_done; @(negedge clk);
    chk("R5 latency after mismatches", int'(latency), 8);
    chk("R8 detected during run", int'(detected), 1);
    load_and_start(8'hFE, 3);
    wait_done; @(negedge clk);
    chk("R6 compensating at cap", int'(compensating), 1);
    chk("R6 latency saturates", int'(latency), CAP);
    mode = 2; cycles(20);
    chk("R7 compensating held", int'(compensating), 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; mode = 0;
    @(negedge clk);
    chk("R9 reset clears done", int'(done), 0);
    chk("R9 reset reloads seed", int'(vec_out), 2);
    cycles(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule